// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a serial port with four operating modes picked by a two-bit mode input. Mode 0 is a synchronous shift register. In that mode the data line carries the bits in both directions, and the second serial pin drives the shift clock. Modes 1, 2 and 3 are asynchronous UART modes. Mode 1 sends 8 data bits and modes 2 and 3 send 9 data bits. Mode 2 runs at a fixed rate derived from the system clock. Modes 1 and 3 run from an external 16x baud tick.

Software writes a byte through a one-cycle write strobe and reads the last received byte from a register output. Sticky completion flags report the end of each transfer and each reception. The flags drop only when their clear inputs are pulsed. The bidirectional data line is split into an input, an output and an output enable, so that the pad can sit outside the block.

Top module: `sport4`

## Requirements
- R1: After reset, `txd_sclk` is high, `sd_oe` is low, and both `tx_flag` and `rx_flag` are low.
- R2: In mode 0 (`mode`=00), a write sends 8 bits least significant bit first on `sd_out` with `sd_oe` high. Each bit lasts 12 clocks. `txd_sclk` is low for the first 6 clocks of each bit and high for the last 6. The bits are valid at its rising edges. `tx_flag` is set 96 clocks after the write.
- R3: In mode 0, a reception starts only while `rx_flag`=0 and `rx_en`=1. It takes `sd_in` at each rising edge of `txd_sclk`, least significant bit first, and loads the byte into `rx_data` when it completes. With `rx_flag`=1 or `rx_en`=0, `txd_sclk` stays high.
- R4: In modes 1, 2 and 3, `txd_sclk` idles high. A frame is a low start bit, then 8 data bits LSB first, then (in modes 2 and 3 only) `tx_bit9`, then a high stop bit. Each bit lasts 16 ticks.
- R5: In mode 2 (`mode`=10), a bit lasts 64 clocks when `slow_rate`=1 and 32 clocks when `slow_rate`=0. In modes 1 and 3, each bit lasts 16 `baud_tick` pulses.
- R6: In UART modes, a falling edge on `sd_in` starts a reception only while `rx_en`=1. The receiver reads samples 7, 8 and 9 of the 16 in each bit and takes their majority, so a glitch one tick wide in mid-bit has no effect.
- R7: A start bit whose majority sample reads high is dropped. The receiver goes back to idle, leaves `rx_flag` unchanged and accepts the next frame.
- R8: In modes 2 and 3, the 9th received bit goes to `rx_bit9`. In mode 1, `rx_bit9` takes the stop bit. In mode 1 with `stop_gate`=1, a frame with a low stop bit is discarded, and `rx_flag` and `rx_data` keep their values.
- R9: `tx_flag` is set when a transmission ends and `rx_flag` is set when a reception ends. Each one stays set until its clear input is pulsed.
- R10: A write while a transfer is in progress is ignored. The frame on the line keeps the first byte, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mode select: 00 shift, 01 8-bit UART, 10 9-bit fixed rate, 11 9-bit tick rate |
| rx_en | input | 1 | Receive enable |
| stop_gate | input | 1 | Mode 1: discard frames with a low stop bit |
| tx_bit9 | input | 1 | 9th bit sent in modes 2 and 3 |
| slow_rate | input | 1 | Mode 2 rate: 1 gives 64 clocks per bit, 0 gives 32 |
| baud_tick | input | 1 | 16x bit-rate tick for modes 1 and 3 |
| tx_wr | input | 1 | Write strobe for transmit data |
| tx_data | input | 8 | Byte to transmit |
| tx_flag_clr | input | 1 | Clears tx_flag |
| rx_flag_clr | input | 1 | Clears rx_flag |
| rx_data | output | 8 | Last received byte |
| rx_bit9 | output | 1 | 9th received bit or stop bit |
| tx_flag | output | 1 | Transmission complete flag |
| rx_flag | output | 1 | Reception complete flag |
| sd_in | input | 1 | Serial data line input |
| sd_out | output | 1 | Serial data line output (mode 0) |
| sd_oe | output | 1 | Output enable for the data line |
| txd_sclk | output | 1 | UART transmit line, or shift clock in mode 0 |

## Verification
The hardest state to reach is a receive vote that disagrees with itself: one of the three mid-bit samples differs from the other two, or the start bit collapses before its samples complete. The bench drives a low pulse only three ticks wide to produce the false start. It then places a one-tick-wide inverted glitch at the centre of data bits, so that exactly one vote in the majority is corrupted. Mode 0 reception is started and held off by changing `rx_en` and leaving `rx_flag` set, while the bench watches whether any shift clock appears.

// File: rtl/sport4.sv
module sport4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rx_en,
  input  logic       stop_gate,
  input  logic       tx_bit9,
  input  logic       slow_rate,
  input  logic       baud_tick,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_flag_clr,
  input  logic       rx_flag_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       tx_flag,
  output logic       rx_flag,
  input  logic       sd_in,
  output logic       sd_out,
  output logic       sd_oe,
  output logic       txd_sclk
);
  localparam logic [1:0] M_SHIFT = 2'b00, M_U8 = 2'b01, M_U9F = 2'b10;
  localparam int M0_HALF = 6, M0_LAST = 11, PH_LAST = 15;

  wire m0   = (mode == M_SHIFT);
  wire nine = mode[1];

  logic [1:0] pre;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 2'd1;
  wire fix_tick = slow_rate ? (pre == 2'd3) : pre[0];
  wire tick     = (mode == M_U9F) ? fix_tick : baud_tick;

  logic [1:0] sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], sd_in};
  wire rxs = sync[1];

  // transmit engine, shared with mode-0 reception
  logic        tbusy, m0rx;
  logic [3:0]  tph, tbit;
  logic [10:0] tsr;
  wire       tstep   = m0 ? 1'b1 : tick;
  wire       tlastph = m0 ? (tph == 4'(M0_LAST)) : (tph == 4'(PH_LAST));
  wire [3:0] tbits   = m0 ? 4'd7 : (nine ? 4'd10 : 4'd9);
  wire       m0go    = m0 && !tx_wr && rx_en && !rx_flag;
  wire       tdone   = tbusy && tstep && tlastph && (tbit == tbits);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tbusy <= 1'b0; m0rx <= 1'b0; tph <= '0; tbit <= '0; tsr <= '1;
    end else if (!tbusy) begin
      if (tx_wr) begin
        tbusy <= 1'b1; m0rx <= 1'b0; tph <= '0; tbit <= '0;
        tsr   <= m0 ? {3'b111, tx_data} : {1'b1, nine ? tx_bit9 : 1'b1, tx_data, 1'b0};
      end else if (m0go) begin
        tbusy <= 1'b1; m0rx <= 1'b1; tph <= '0; tbit <= '0;
      end
    end else if (tstep) begin
      tph <= tlastph ? 4'd0 : tph + 4'd1;
      if (m0rx && tph == 4'(M0_HALF)) tsr[7:0] <= {rxs, tsr[7:1]};
      if (tlastph) begin
        if (!m0rx) tsr <= {1'b1, tsr[10:1]};
        tbit <= tbit + 4'd1;
        if (tbit == tbits) tbusy <= 1'b0;
      end
    end

  assign sd_oe    = tbusy && m0 && !m0rx;
  assign sd_out   = tsr[0];
  assign txd_sclk = !tbusy ? 1'b1 : (m0 ? (tph >= 4'(M0_HALF)) : tsr[0]);

  // UART receiver
  logic       rbusy, rlast;
  logic [3:0] rph, rbit;
  logic [1:0] vote;
  logic [8:0] rsr;
  wire       rstep = tick && !m0;
  wire       maj   = (vote[0] & vote[1]) | (vote[0] & rxs) | (vote[1] & rxs);
  wire [3:0] rbits = nine ? 4'd10 : 4'd9;
  wire       rdone = rstep && rbusy && rph == 4'd9 && rbit == rbits;
  wire       r_ok  = !(mode == M_U8 && stop_gate && !maj);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbusy <= 1'b0; rlast <= 1'b1; rph <= '0; rbit <= '0; vote <= '0; rsr <= '0;
    end else if (rstep) begin
      rlast <= rxs;
      if (!rbusy) begin
        if (rx_en && rlast && !rxs) begin
          rbusy <= 1'b1; rph <= 4'd1; rbit <= '0;
        end
      end else begin
        rph <= rph + 4'd1;
        if (rph == 4'd7) vote[0] <= rxs;
        if (rph == 4'd8) vote[1] <= rxs;
        if (rph == 4'd15) rbit <= rbit + 4'd1;
        if (rph == 4'd9) begin
          if (rbit == 4'd0) begin
            if (maj) rbusy <= 1'b0;
          end else if (rbit == rbits) rbusy <= 1'b0;
          else rsr <= {maj, rsr[8:1]};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_flag <= 1'b0; rx_flag <= 1'b0; rx_data <= '0; rx_bit9 <= 1'b0;
    end else begin
      if (tx_flag_clr) tx_flag <= 1'b0;
      if (rx_flag_clr) rx_flag <= 1'b0;
      if (tdone && !m0rx) tx_flag <= 1'b1;
      if (tdone && m0rx) begin
        rx_flag <= 1'b1;
        rx_data <= tsr[7:0];
      end
      if (rdone && r_ok) begin
        rx_flag <= 1'b1;
        rx_data <= nine ? rsr[7:0] : rsr[8:1];
        rx_bit9 <= nine ? rsr[8] : maj;
      end
    end
endmodule

// File: rtl/sport4_chk.sv
module sport4_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic tx_flag,
  input logic rx_flag,
  input logic tx_flag_clr,
  input logic rx_flag_clr,
  input logic tbusy,
  input logic m0rx,
  input logic rbusy
);
  // R9
  ti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flag && !tx_flag_clr |=> tx_flag);
  // R9
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rx_flag_clr |=> rx_flag);
  // R2
  ti_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $fell(tbusy));
  // R3
  m0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbusy) && m0rx |-> $past(rx_en) && !$past(rx_flag));
  // R6
  rx_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbusy) |-> $past(rx_en));
endmodule

bind sport4 sport4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_flag(tx_flag), .rx_flag(rx_flag),
  .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
  .tbusy(tbusy), .m0rx(m0rx), .rbusy(rbusy)
);

// File: tb/sim_sport4.sv
module sim_sport4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rx_en = 1'b0, stop_gate = 1'b0, tx_bit9 = 1'b0, slow_rate = 1'b0, baud_tick = 1'b0;
  logic tx_wr = 1'b0, tx_flag_clr = 1'b0, rx_flag_clr = 1'b0, sd_in = 1'b1;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic rx_bit9, tx_flag, rx_flag, sd_out, sd_oe, txd_sclk;
  int tests = 0, fails = 0;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  sport4 u0 (.*);

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 3);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_flags();
    @(negedge clk); tx_flag_clr = 1'b1; rx_flag_clr = 1'b1;
    @(negedge clk); tx_flag_clr = 1'b0; rx_flag_clr = 1'b0;
  endtask

  task automatic m0_tx(input logic [7:0] d);
    logic [7:0] got; int nb; int k; logic ptx; logic oe_ok;
    @(negedge clk); mode = 2'b00; rx_en = 1'b0; tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0; ptx = txd_sclk; nb = 0; k = 0; got = '0; oe_ok = 1'b1;
    while (!tx_flag && k < 300) begin
      @(negedge clk); k++;
      if (!sd_oe && !tx_flag) oe_ok = 1'b0;
      if (!ptx && txd_sclk && nb < 8) begin got[nb] = sd_out; nb++; end
      ptx = txd_sclk;
    end
    chk(got == d && nb == 8, "R2 mode0 tx bits", {24'd0, got}, {24'd0, d});
    chk(k == 96, "R2 mode0 tx length", k, 96);
    chk(oe_ok, "R2 mode0 oe held", 0, 1);
    @(negedge clk);
    chk(tx_flag, "R9 tx_flag held", 32'(tx_flag), 1);
    clr_flags();
    chk(!tx_flag, "R9 tx_flag cleared", 32'(tx_flag), 0);
  endtask

  task automatic m0_rx(input logic [7:0] d, input bit hold_test);
    int idx; int k; logic ptx; logic quiet;
    @(negedge clk); mode = 2'b00; sd_in = 1'b1; rx_en = 1'b1; ptx = 1'b1; idx = 0; k = 0;
    while (!rx_flag && k < 300) begin
      @(negedge clk); k++;
      if (ptx && !txd_sclk && idx < 8) begin sd_in = d[idx]; idx++; end
      ptx = txd_sclk;
    end
    sd_in = 1'b1;
    chk(rx_flag && rx_data == d, "R3 mode0 rx byte", {24'd0, rx_data}, {24'd0, d});
    if (hold_test) begin
      quiet = 1'b1;
      repeat (30) begin @(negedge clk); if (!txd_sclk) quiet = 1'b0; end
      chk(quiet, "R3 no start while rx_flag set", 0, 1);
    end
    @(negedge clk); rx_en = 1'b0;
    clr_flags();
    if (hold_test) begin
      quiet = 1'b1;
      repeat (30) begin @(negedge clk); if (!txd_sclk) quiet = 1'b0; end
      chk(quiet && !rx_flag, "R3 no start while rx_en low", 32'(rx_flag), 0);
    end
  endtask

  task automatic u_tx(input logic [1:0] m, input logic s64, input logic [7:0] d, input logic b9,
                      input int bc, input bit poke);
    logic [10:0] exp; logic [10:0] got; int n; logic quiet;
    n   = m[1] ? 11 : 10;
    exp = m[1] ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    got = '1;
    @(negedge clk); mode = m; slow_rate = s64; tx_bit9 = b9; tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd_sclk;
      if (poke && i == 3) begin
        tx_data = ~d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        repeat (bc - 1) @(negedge clk);
      end else repeat (bc) @(negedge clk);
    end
    if (m == 2'b10) chk(got == exp, "R5 mode2 frame at rate", {21'd0, got}, {21'd0, exp});
    else if (poke) chk(got == exp, "R10 frame kept first byte", {21'd0, got}, {21'd0, exp});
    else chk(got == exp, "R4 uart tx frame", {21'd0, got}, {21'd0, exp});
    chk(tx_flag && txd_sclk, "R9 tx_flag after frame", {30'd0, tx_flag, txd_sclk}, 3);
    if (poke) begin
      quiet = 1'b1;
      repeat (2 * bc) begin @(negedge clk); if (!txd_sclk) quiet = 1'b0; end
      chk(quiet, "R10 no second frame", 0, 1);
    end
    clr_flags();
  endtask

  task automatic u_rx(input logic [1:0] m, input logic s64, input logic sg, input logic [7:0] d,
                      input logic b9, input logic stp, input int bc, input bit glitch,
                      input bit exp_ok, input string tag);
    logic [10:0] fr; int n; logic [7:0] old;
    n   = m[1] ? 11 : 10;
    fr  = m[1] ? {stp, b9, d, 1'b0} : {1'b1, stp, d, 1'b0};
    old = rx_data;
    @(negedge clk); mode = m; slow_rate = s64; stop_gate = sg; rx_en = 1'b1; sd_in = 1'b1;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sd_in = fr[i];
      if (glitch && i >= 1 && i <= 8) begin
        repeat (bc / 2 - 2) @(negedge clk);
        sd_in = ~fr[i]; repeat (4) @(negedge clk); sd_in = fr[i];
        repeat (bc - bc / 2 - 2) @(negedge clk);
      end else repeat (bc) @(negedge clk);
    end
    sd_in = 1'b1;
    repeat (bc) @(negedge clk);
    if (exp_ok) begin
      chk(rx_flag && rx_data == d, tag, {23'd0, rx_flag, rx_data}, {23'd0, 1'b1, d});
      chk(rx_bit9 == (m[1] ? b9 : stp), "R8 ninth/stop bit", 32'(rx_bit9), 32'(m[1] ? b9 : stp));
    end else
      chk(!rx_flag && rx_data == old, tag, {23'd0, rx_flag, rx_data}, {23'd0, 1'b0, old});
    clr_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd_sclk && !sd_oe && !tx_flag && !rx_flag, "R1 reset state",
        {28'd0, txd_sclk, sd_oe, tx_flag, rx_flag}, 32'h8);

    for (int i = 0; i < 12; i++) m0_tx(8'((i * 37) ^ 8'h5A));
    m0_tx(8'h00); m0_tx(8'hFF);

    m0_rx(8'hA5, 1'b1);
    for (int i = 0; i < 6; i++) m0_rx(8'((i * 73) + 8'h13), 1'b0);

    for (int i = 0; i < 4; i++) u_tx(2'b01, 1'b0, 8'((i * 91) ^ 8'h3C), 1'b0, 64, 1'b0);
    u_tx(2'b11, 1'b0, 8'h81, 1'b1, 64, 1'b0);
    u_tx(2'b11, 1'b0, 8'h7E, 1'b0, 64, 1'b0);
    u_tx(2'b10, 1'b1, 8'hC3, 1'b1, 64, 1'b0);
    u_tx(2'b10, 1'b0, 8'h2D, 1'b0, 32, 1'b0);
    u_tx(2'b10, 1'b0, 8'hF0, 1'b1, 32, 1'b0);
    u_tx(2'b01, 1'b0, 8'h96, 1'b0, 64, 1'b1);

    for (int i = 0; i < 3; i++)
      u_rx(2'b01, 1'b0, 1'b0, 8'((i * 59) ^ 8'hC5), 1'b0, 1'b1, 64, 1'b0, 1'b1, "R6 mode1 rx byte");
    u_rx(2'b01, 1'b0, 1'b0, 8'h4B, 1'b0, 1'b0, 64, 1'b0, 1'b1, "R8 mode1 low stop kept");
    u_rx(2'b01, 1'b0, 1'b1, 8'hB4, 1'b0, 1'b0, 64, 1'b0, 1'b0, "R8 mode1 gated frame dropped");
    u_rx(2'b11, 1'b0, 1'b0, 8'h69, 1'b1, 1'b1, 64, 1'b0, 1'b1, "R8 mode3 rx");
    u_rx(2'b10, 1'b1, 1'b0, 8'h1E, 1'b0, 1'b1, 64, 1'b0, 1'b1, "R5 mode2 slow rx");
    u_rx(2'b10, 1'b0, 1'b0, 8'hE1, 1'b1, 1'b1, 32, 1'b0, 1'b1, "R5 mode2 fast rx");
    u_rx(2'b01, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 64, 1'b1, 1'b1, "R6 majority rejects glitch");
    u_rx(2'b11, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b1, 64, 1'b1, 1'b1, "R6 majority mode3 glitch");

    @(negedge clk); mode = 2'b01; rx_en = 1'b1; sd_in = 1'b0;
    repeat (12) @(negedge clk); sd_in = 1'b1;
    repeat (192) @(negedge clk);
    chk(!rx_flag, "R7 false start dropped", 32'(rx_flag), 0);
    u_rx(2'b01, 1'b0, 1'b0, 8'h3D, 1'b0, 1'b1, 64, 1'b0, 1'b1, "R7 frame after false start");

    @(negedge clk); rx_en = 1'b0; sd_in = 1'b0;
    repeat (64) @(negedge clk); sd_in = 1'b1;
    repeat (640) @(negedge clk);
    chk(!rx_flag, "R6 rx_en low ignores frame", 32'(rx_flag), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule